// File: doc/BRIEF.md
# Third-Order MASH Divide-Ratio Controller

This block drives the modulus input of a multi-modulus feedback divider in a fractional-N frequency synthesizer. It takes a static divide ratio, given as an integer part and an unsigned fixed-point fraction, and runs once per reference cycle. On each cycle it issues one integer divide value. Averaged over many cycles, those values equal the programmed ratio. A typical setting is 73 plus a fraction of about 0.313, with a reference near 35 MHz.

The fraction is noise-shaped by three cascaded first-order error-feedback accumulators. Each accumulator adds the wrapped sum of the previous stage. The three overflow bits are recombined with first and second differences, so that the quantization error of the earlier stages cancels. The recombined step lies between -3 and +4. It is added to the integer part and the total is clamped to the range the divider supports. The first accumulator's overflow bit and its residue are also exported. The residue tracks the instantaneous phase error, so a cancellation DAC next to the phase detector can use it.

Top module: `fracn_mash_ctrl`

## Requirements
- R1: A synchronous reset clears all accumulators and difference history. On the first cycle after reset is released, `residue` is 0, `carry1` is 0 and `div_value` equals `int_part`, whatever `frac_word` was during reset.
- R2: With `frac_word` at 0 from reset on, `div_value` equals `int_part` on every cycle.
- R3: On every clock edge out of reset, `residue` becomes (previous `residue` + `frac_word`) mod 2^16. The 16-bit `frac_word` is read as the fraction `frac_word`/65536.
- R4: `carry1` is 1 exactly on those cycles whose first-stage addition in R3 wrapped past 2^16, and 0 otherwise.
- R5: When `int_part` lies in 67..74, `div_value` - `int_part` is always within -3..+4.
- R6: `div_value` is always within 64..78 inclusive. A step that would leave this range saturates at the nearest bound, so with `int_part` 64 and a nonzero fraction the value 64 is reached, and with `int_part` 78 the value 78 is reached.
- R7: Hold `int_part` in 67..74 and `frac_word` constant, starting from reset. The sum of `div_value` over the next 65536 cycles then differs from `int_part`·65536 + `frac_word` by no less than -1 and no more than +2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| int_part | input | 7 | Integer part of the divide ratio |
| frac_word | input | 16 | Fraction of the divide ratio, unsigned, scaled by 2^16 |
| div_value | output | 7 | Divide value for the current reference cycle |
| carry1 | output | 1 | First-stage overflow of the last update |
| residue | output | 16 | First-stage accumulator contents, for the cancellation DAC |

## Verification
A zero fraction shows that the integer part passes through untouched. A fraction near 0.313 and the fraction one half are each run for a full 2^16-cycle window, and the summed divide values are compared with the programmed ratio. This tells a correct fractional average apart from a lost or doubled carry. A stretch of frequent fraction changes, including 0x0001 and 0xFFFF, checks the first-stage residue and overflow against an independent running sum on every cycle. Integer parts of 64 and 78 push the noise-shaped step against both clamp bounds, which separates saturation from wrap-around.

// File: rtl/fracn_mash_pkg.sv
package fracn_mash_pkg;
   // width of the recombined signed step (-3..+4 fits in 4 bits)
   localparam int STEP_W    = 4;
   localparam int MAX_ORDER = 3;
   localparam int STEP_LO   = -3;
   localparam int STEP_HI   = 4;

   typedef logic signed [STEP_W-1:0] mash_step_t;
endpackage

// File: rtl/mash_acc_stage.sv
// One first-order error-feedback accumulator: wraps modulo 2^W and
// reports the wrap as a carry in the same cycle.
module mash_acc_stage #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] addend,
   output logic         carry_o,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] acc_o
);
   logic [W:0]   total;
   logic [W-1:0] acc_q;

   assign total = {1'b0, acc_q} + {1'b0, addend};

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= total[W-1:0];
   end

   assign carry_o = total[W];
   assign sum_o   = total[W-1:0];
   assign acc_o   = acc_q;
endmodule

// File: rtl/mash_noise_comb.sv
// Recombines the stage carries so that earlier-stage error cancels:
// c1 + diff(c2) + diff2(c3), truncated to the configured order.
module mash_noise_comb
   import fracn_mash_pkg::*;
#(
   parameter int ORDER = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ORDER-1:0] carries,
   output mash_step_t       step_o
);
   function automatic mash_step_t as_step(input logic b);
      return mash_step_t'({{(STEP_W-1){1'b0}}, b});
   endfunction

   if (ORDER == 1) begin : g_ord1
      assign step_o = as_step(carries[0]);
   end else if (ORDER == 2) begin : g_ord2
      logic c2_d;
      always_ff @(posedge clk) begin
         if (rst) c2_d <= 1'b0;
         else     c2_d <= carries[1];
      end
      assign step_o = as_step(carries[0]) + as_step(carries[1]) - as_step(c2_d);
   end else begin : g_ord3
      logic c2_d, c3_d, c3_dd;
      always_ff @(posedge clk) begin
         if (rst) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
         end else begin
            c2_d  <= carries[1];
            c3_d  <= carries[2];
            c3_dd <= c3_d;
         end
      end
      assign step_o = as_step(carries[0])
                    + as_step(carries[1]) - as_step(c2_d)
                    + as_step(carries[2]) - (as_step(c3_d) <<< 1) + as_step(c3_dd);
   end
endmodule

// File: rtl/fracn_mash_ctrl.sv
module fracn_mash_ctrl
   import fracn_mash_pkg::*;
#(
   parameter int INT_W    = 7,
   parameter int FRAC_W   = 16,
   parameter int ORDER    = 3,
   parameter int DIV_MIN  = 64,
   parameter int DIV_MAX  = 78,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [INT_W-1:0]  int_part,
   input  logic [FRAC_W-1:0] frac_word,
   output logic [INT_W-1:0]  div_value,
   output logic              carry1,
   output logic [FRAC_W-1:0] residue
);
   localparam int RAW_W = INT_W + 2;

   // elaboration-time parameter checks
   if (ORDER < 1 || ORDER > MAX_ORDER) begin : g_bad_order
      $error("fracn_mash_ctrl: ORDER must be 1..%0d", MAX_ORDER);
   end
   if (DIV_MIN > DIV_MAX) begin : g_bad_range
      $error("fracn_mash_ctrl: DIV_MIN exceeds DIV_MAX");
   end
   if (DIV_MAX >= (1 << INT_W) || DIV_MIN < 0) begin : g_bad_width
      $error("fracn_mash_ctrl: divide bounds do not fit INT_W");
   end
   if (RAW_W <= STEP_W) begin : g_bad_int_w
      $error("fracn_mash_ctrl: INT_W too small");
   end

   logic [FRAC_W-1:0] st_sum [ORDER];
   logic [FRAC_W-1:0] st_acc [ORDER];
   logic [ORDER-1:0]  st_carry;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic [FRAC_W-1:0] addend;
      if (k == 0) begin : g_head
         assign addend = frac_word;
      end else begin : g_tail
         assign addend = st_sum[k-1];
      end
      mash_acc_stage #(.W(FRAC_W)) u_acc (
         .clk     (clk),
         .rst     (rst),
         .addend  (addend),
         .carry_o (st_carry[k]),
         .sum_o   (st_sum[k]),
         .acc_o   (st_acc[k])
      );
   end

   mash_step_t step_next;
   mash_step_t step_q;
   logic       c1_q;

   mash_noise_comb #(.ORDER(ORDER)) u_comb (
      .clk     (clk),
      .rst     (rst),
      .carries (st_carry),
      .step_o  (step_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
         c1_q   <= 1'b0;
      end else begin
         step_q <= step_next;
         c1_q   <= st_carry[0];
      end
   end

   assign carry1  = c1_q;
   assign residue = st_acc[0];

   logic signed [RAW_W-1:0] step_ext;
   logic signed [RAW_W-1:0] raw_div;

   assign step_ext = RAW_W'(step_q);
   assign raw_div  = $signed({2'b00, int_part}) + step_ext;

   if (CLAMP_EN) begin : g_clamp
      localparam logic signed [RAW_W-1:0] LO = RAW_W'(DIV_MIN);
      localparam logic signed [RAW_W-1:0] HI = RAW_W'(DIV_MAX);
      always_comb begin
         if (raw_div < LO)      div_value = LO[INT_W-1:0];
         else if (raw_div > HI) div_value = HI[INT_W-1:0];
         else                   div_value = raw_div[INT_W-1:0];
      end
   end else begin : g_wrap
      assign div_value = raw_div[INT_W-1:0];
   end
endmodule

// File: rtl/fracn_mash_ctrl_chk.sv
module fracn_mash_ctrl_chk #(
   parameter int INT_W   = 7,
   parameter int FRAC_W  = 16,
   parameter int DIV_MIN = 64,
   parameter int DIV_MAX = 78
) (
   input logic              clk,
   input logic              rst,
   input logic [INT_W-1:0]  int_part,
   input logic [FRAC_W-1:0] frac_word,
   input logic [INT_W-1:0]  div_value,
   input logic              carry1,
   input logic [FRAC_W-1:0] residue
);
   logic rst_d = 1'b1;
   always @(posedge clk) rst_d <= rst;

   // R1: first cycle after reset shows cleared state
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (residue == '0 && !carry1));

   // R3: residue advances by the fraction modulo 2^FRAC_W
   p_residue_step_r3: assert property (@(posedge clk) disable iff (rst)
      !rst_d |-> residue == FRAC_W'($past(residue) + $past(frac_word)));

   // R4: overflow flagged exactly when the new residue wrapped below the addend
   p_carry_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      !rst_d |-> carry1 == (residue < $past(frac_word)));

   // R5: step bounded when no clamping can occur
   p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (int'(int_part) >= DIV_MIN + 3 && int'(int_part) <= DIV_MAX - 4) |->
      ((int'(div_value) - int'(int_part)) >= -3 && (int'(div_value) - int'(int_part)) <= 4));

   // R6: divide value never leaves the supported modulus range
   p_div_range_r6: assert property (@(posedge clk) disable iff (rst)
      (int'(div_value) >= DIV_MIN && int'(div_value) <= DIV_MAX));
endmodule

bind fracn_mash_ctrl fracn_mash_ctrl_chk #(
   .INT_W   (INT_W),
   .FRAC_W  (FRAC_W),
   .DIV_MIN (DIV_MIN),
   .DIV_MAX (DIV_MAX)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .int_part  (int_part),
   .frac_word (frac_word),
   .div_value (div_value),
   .carry1    (carry1),
   .residue   (residue)
);

// File: tb/fracn_mash_ctrl_bench.sv
module fracn_mash_ctrl_bench;
   localparam int FW = 16;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IW-1:0] int_part = 7'd73;
   logic [FW-1:0] frac_word = '0;
   wire  [IW-1:0] div_value;
   wire           carry1;
   wire  [FW-1:0] residue;

   always #10 clk = ~clk;

   fracn_mash_ctrl u_fracn_mash_ctrl (
      .clk       (clk),
      .rst       (rst),
      .int_part  (int_part),
      .frac_word (frac_word),
      .div_value (div_value),
      .carry1    (carry1),
      .residue   (residue)
   );

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   typedef struct {
      bit            carry;
      logic [FW-1:0] res;
   } exp_t;

   exp_t          sb_q[$];
   logic [FW-1:0] model_acc = '0;
   longint        win_sum = 0;
   bit            win_en  = 1'b0;
   int            seen_min = 1000;
   int            seen_max = -1000;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: predicts the first-stage result of the next edge and queues it
   task automatic drive(input int n);
      for (int i = 0; i < n; i++) begin
         logic [FW:0] tot;
         exp_t e;
         tot = {1'b0, model_acc} + {1'b0, frac_word};
         e.carry = tot[FW];
         e.res   = tot[FW-1:0];
         model_acc = tot[FW-1:0];
         sb_q.push_back(e);
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // monitor: pops one expectation per edge and compares after the edge
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         int d, ip;
         e = sb_q.pop_front();
         #5;
         d  = int'(div_value);
         ip = int'(int_part);
         check(residue == e.res,   "R3", "residue", residue, e.res);
         check(carry1  == e.carry, "R4", "carry1",  carry1,  e.carry);
         check(d >= 64 && d <= 78, "R6", "div_value range", d, 64);
         if (ip >= 67 && ip <= 74)
            check((d - ip) >= -3 && (d - ip) <= 4, "R5", "step", d - ip, ip);
         if (win_en) win_sum += d;
         if (d < seen_min) seen_min = d;
         if (d > seen_max) seen_max = d;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      model_acc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic window(input logic [IW-1:0] ip, input logic [FW-1:0] fw, input string tag);
      longint expect_sum, diff;
      int_part  = ip;
      frac_word = fw;
      do_reset();
      win_sum = 0;
      win_en  = 1'b1;
      drive(65536);
      win_en  = 1'b0;
      expect_sum = longint'(ip) * 65536 + longint'(fw);
      diff = win_sum - expect_sum;
      check(diff >= -1 && diff <= 2, "R7", tag, win_sum, expect_sum);
   endtask

   initial begin
      // R1: reset clears state even with a nonzero fraction applied
      frac_word = 16'h1234;
      int_part  = 7'd73;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(residue == 0, "R1", "residue in reset", residue, 0);
      frac_word = 16'h0000;
      do_reset();
      check(residue == 0,        "R1", "residue after reset", residue, 0);
      check(carry1 == 1'b0,      "R1", "carry1 after reset",  carry1, 0);
      check(div_value == 7'd73,  "R1", "div_value after reset", div_value, 73);

      // R2: zero fraction leaves the integer untouched
      for (int i = 0; i < 64; i++) begin
         drive(1);
         check(div_value == int_part, "R2", "zero fraction", div_value, int_part);
      end

      // R7: long-run averages for two fractions
      window(7'd73, 16'h5025, "average 73+0x5025");
      window(7'd70, 16'h8000, "average 70+0x8000");

      // R3/R4: fraction changed often, including extremes
      int_part = 7'd73;
      frac_word = 16'h0001; drive(50);
      frac_word = 16'hFFFF; drive(50);
      frac_word = 16'hA5A5; drive(50);
      frac_word = 16'h0000; drive(20);
      frac_word = 16'h7FFF; drive(50);

      // R1: reset in the middle of a run
      do_reset();
      check(residue == 0,       "R1", "residue after mid-run reset", residue, 0);
      check(carry1 == 1'b0,     "R1", "carry1 after mid-run reset",  carry1, 0);
      check(div_value == 7'd73, "R1", "div_value after mid-run reset", div_value, 73);

      // R6: saturation at the lower bound
      int_part = 7'd64; frac_word = 16'h5025;
      do_reset();
      seen_min = 1000; seen_max = -1000;
      drive(3000);
      check(seen_min == 64, "R6", "lowest value with int 64", seen_min, 64);

      // R6: saturation at the upper bound
      int_part = 7'd78; frac_word = 16'h5025;
      do_reset();
      seen_min = 1000; seen_max = -1000;
      drive(3000);
      check(seen_max == 78, "R6", "highest value with int 78", seen_max, 78);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule